// File: doc/BRIEF.md
# Split-Phase First-Level Cache Bus Controller

This controller sits between a processor and its first-level cache SRAMs. The processor uses one shared tag/data bus for two transactions in each processor clock. The instruction address goes out in the second half-phase and the instruction comes back in the next first half-phase. The data address goes out in the first half-phase and the data moves in the second half-phase that follows. The controller latches each address in the half-phase where it appears, which gives the SRAM lookup the time until the return phase. It compares the stored tag and answers hits in the right phase.

A miss, an access to the uncached kernel window, or any data write is sent to the higher-level memory port. The controller then holds the processor in a stall. The sequence is miss request, stall with the fill delivered, one fix-up cycle, and then run. A miss therefore takes at least four processor cycles, counting the cycle in which it is detected.

The controller runs on a clock at twice the processor rate. The `ph_two` output marks which half-phase is current. Each SRAM array is direct-mapped with one word per entry. The arrays and the higher-level memory are outside the block.

Top module: `l1_split_ctrl`

## Requirements
- R1: After reset the first tick is phase one (`ph_two`=0) and the phase alternates every tick. An instruction address with `i_valid` is accepted in a phase-two tick when `stall` is low. On a hit, `i_rdy` pulses with the array word in the very next tick, which is phase one. `i_rdy` never rises in phase two.
- R2: A data read with `d_valid` is accepted in a phase-one tick. On a hit, `d_rdy` pulses with the array word in the next tick, which is phase two. `d_rdy` never rises in phase one.
- R3: The array index is address bits [IDX_W+1:2] and the tag is bits [31:IDX_W+2]. An access hits only when the entry is valid and its stored tag equals the tag bits. An invalid entry or a different tag is a miss.
- R4: On a miss, `stall` is high in the phase-two tick of the detecting cycle. `mem_req` is then raised. The fill word is returned in its own phase in the cycle after the acknowledge cycle. One fix-up cycle follows, and `stall` falls in the fix-up phase-two tick. With acknowledge delay D ticks, the run stalls for 3+floor(D/2) processor cycles after the detecting cycle.
- R5: A cached read miss writes the fill word and its tag into the array, so the same access then hits with no memory request.
- R6: Addresses whose top three bits are 101 (0xA000_0000 to 0xBFFF_FFFF) always go to the memory port, even when the array holds a matching entry. They are never written into the array.
- R7: Every data write goes to the memory port with `mem_we`=1 and the write data, and it takes the full miss sequence with no `d_rdy`. A cached write that hits also updates the array word. A cached write that misses allocates nothing.
- R8: `i_map`/`d_map` flag a pending address that needs translation: top bit 0 (user, mapped) or top bits 11 (kernel, mapped). The flag is low for the 100 and 101 windows.
- R9: When the instruction and the data both miss in one cycle, the instruction request is issued first and then the data request. Only one fix-up cycle follows, so the stall lasts 5+2*floor(D/2) cycles.
- R10: During reset `stall`, `mem_req`, `i_rdy`, `d_rdy` and `ph_two` are all low.
- R11: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_we` and `mem_req` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock, two ticks per processor cycle |
| rst | input | 1 | Synchronous reset, active high |
| ph_two | output | 1 | High during the phase-two tick |
| stall | output | 1 | Processor must hold its addresses |
| i_addr | input | 32 | Instruction address, phase two |
| i_valid | input | 1 | Instruction fetch present |
| i_data | output | DATA_W | Returned instruction |
| i_rdy | output | 1 | Instruction returned this tick |
| i_map | output | 1 | Pending instruction address needs translation |
| d_addr | input | 32 | Data address, phase one |
| d_valid | input | 1 | Data access present |
| d_we | input | 1 | Data access is a write |
| d_wdata | input | DATA_W | Write data |
| d_rdata | output | DATA_W | Returned read data |
| d_rdy | output | 1 | Read data returned this tick |
| d_map | output | 1 | Pending data address needs translation |
| isram_idx | output | IDX_W | Instruction array index |
| isram_rvalid | input | 1 | Instruction entry valid bit |
| isram_rtag | input | 30-IDX_W | Instruction entry tag |
| isram_rdata | input | DATA_W | Instruction entry word |
| isram_we | output | 1 | Instruction array write |
| isram_wtag | output | 30-IDX_W | Tag to write |
| isram_wdata | output | DATA_W | Word to write |
| dsram_idx | output | IDX_W | Data array index |
| dsram_rvalid | input | 1 | Data entry valid bit |
| dsram_rtag | input | 30-IDX_W | Data entry tag |
| dsram_rdata | input | DATA_W | Data entry word |
| dsram_we | output | 1 | Data array write |
| dsram_wtag | output | 30-IDX_W | Tag to write |
| dsram_wdata | output | DATA_W | Word to write |
| mem_req | output | 1 | Higher-level request |
| mem_addr | output | 32 | Request address |
| mem_we | output | 1 | Request is a write |
| mem_wdata | output | DATA_W | Request write data |
| mem_ack | input | 1 | One-tick acknowledge |
| mem_rdata | input | DATA_W | Fill word, valid with mem_ack |

## Verification
Instruction and data hits are tried over every array index, each with its own word. This separates correct index and tag slicing from an off-by-one field and shows that each return comes in its own half-phase. Misses are forced with a wrong tag and with a cleared valid bit, under acknowledge delays of zero to three ticks. The measured stall length then separates a correct four-cycle minimum from a sequence that skips or repeats the stall or fix-up cycle, and a second access shows whether the fill was kept. Uncached, write-hit, write-miss, mapped-segment and simultaneous-miss patterns each isolate one rule: bypass without fill, write-through with update and no allocate, the translation flag per segment, and instruction-first ordering with a single fix-up.

// File: rtl/l1_split_ctrl.sv
module l1_split_ctrl #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  output logic                ph_two,
  output logic                stall,
  input  logic [31:0]         i_addr,
  input  logic                i_valid,
  output logic [DATA_W-1:0]   i_data,
  output logic                i_rdy,
  output logic                i_map,
  input  logic [31:0]         d_addr,
  input  logic                d_valid,
  input  logic                d_we,
  input  logic [DATA_W-1:0]   d_wdata,
  output logic [DATA_W-1:0]   d_rdata,
  output logic                d_rdy,
  output logic                d_map,
  output logic [IDX_W-1:0]    isram_idx,
  input  logic                isram_rvalid,
  input  logic [29-IDX_W:0]   isram_rtag,
  input  logic [DATA_W-1:0]   isram_rdata,
  output logic                isram_we,
  output logic [29-IDX_W:0]   isram_wtag,
  output logic [DATA_W-1:0]   isram_wdata,
  output logic [IDX_W-1:0]    dsram_idx,
  input  logic                dsram_rvalid,
  input  logic [29-IDX_W:0]   dsram_rtag,
  input  logic [DATA_W-1:0]   dsram_rdata,
  output logic                dsram_we,
  output logic [29-IDX_W:0]   dsram_wtag,
  output logic [DATA_W-1:0]   dsram_wdata,
  output logic                mem_req,
  output logic [31:0]         mem_addr,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int TAG_LO = IDX_W + 2;

  typedef enum logic [1:0] {S_RUN, S_MREQ, S_STALL, S_FIX} st_t;

  function automatic logic is_unc(input logic [31:0] a);
    return a[31:29] == 3'b101;
  endfunction

  function automatic logic is_mapped(input logic [31:0] a);
    return !a[31] || (a[31:30] == 2'b11);
  endfunction

  st_t                st;
  logic               ph;
  logic [31:0]        i_lat, d_lat;
  logic               i_pend, d_pend, dw_q;
  logic [DATA_W-1:0]  dwd_q, fill_q;
  logic               i_miss_q, svc_d, d_wait, req_q, got_ack;

  logic i_hit, d_hit, i_miss_now, d_miss_now, run, ack_now;

  assign run        = (st == S_RUN);
  assign ack_now    = req_q && mem_ack;
  assign i_hit      = isram_rvalid && (isram_rtag == i_lat[31:TAG_LO]);
  assign d_hit      = dsram_rvalid && (dsram_rtag == d_lat[31:TAG_LO]);
  assign i_miss_now = i_pend && (is_unc(i_lat) || !i_hit);
  assign d_miss_now = d_pend && (dw_q || is_unc(d_lat) || !d_hit);

  assign ph_two = ph;
  assign stall  = (st == S_MREQ) || (st == S_STALL) || (st == S_FIX && !ph)
               || (run && ph && (i_miss_q || d_miss_now));

  assign i_rdy  = (run && !ph && i_pend && !is_unc(i_lat) && i_hit)
               || (st == S_STALL && !ph && !svc_d);
  assign i_data = (st == S_STALL) ? fill_q : isram_rdata;
  assign d_rdy  = (run && ph && d_pend && !dw_q && !is_unc(d_lat) && d_hit)
               || (st == S_STALL && ph && svc_d && !dw_q);
  assign d_rdata = (st == S_STALL) ? fill_q : dsram_rdata;

  assign i_map = i_pend && is_mapped(i_lat);
  assign d_map = d_pend && is_mapped(d_lat);

  assign isram_idx   = i_lat[TAG_LO-1:2];
  assign isram_wtag  = i_lat[31:TAG_LO];
  assign isram_wdata = fill_q;
  assign isram_we    = (st == S_STALL) && !ph && !svc_d && !is_unc(i_lat);

  assign dsram_idx   = d_lat[TAG_LO-1:2];
  assign dsram_wtag  = d_lat[31:TAG_LO];
  assign dsram_wdata = dw_q ? dwd_q : fill_q;
  assign dsram_we    = (st == S_STALL) && ph && svc_d && !is_unc(d_lat) && (!dw_q || d_hit);

  assign mem_req   = req_q;
  assign mem_addr  = svc_d ? d_lat : i_lat;
  assign mem_we    = svc_d && dw_q;
  assign mem_wdata = dwd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_RUN;
      ph       <= 1'b0;
      i_lat    <= '0;
      d_lat    <= '0;
      i_pend   <= 1'b0;
      d_pend   <= 1'b0;
      dw_q     <= 1'b0;
      dwd_q    <= '0;
      fill_q   <= '0;
      i_miss_q <= 1'b0;
      svc_d    <= 1'b0;
      d_wait   <= 1'b0;
      req_q    <= 1'b0;
      got_ack  <= 1'b0;
    end else begin
      ph <= ~ph;
      unique case (st)
        S_RUN: begin
          if (!ph) begin
            d_lat    <= d_addr;
            d_pend   <= d_valid;
            dw_q     <= d_we;
            dwd_q    <= d_wdata;
            i_miss_q <= i_miss_now;
          end else if (i_miss_q || d_miss_now) begin
            st      <= S_MREQ;
            svc_d   <= !i_miss_q;
            d_wait  <= i_miss_q && d_miss_now;
            req_q   <= 1'b1;
            got_ack <= 1'b0;
          end else begin
            i_lat  <= i_addr;
            i_pend <= i_valid;
          end
        end
        S_MREQ: begin
          if (ack_now) begin
            req_q   <= 1'b0;
            got_ack <= 1'b1;
            fill_q  <= mem_rdata;
          end
          if (ph && (got_ack || ack_now)) st <= S_STALL;
        end
        S_STALL: begin
          if (ph) begin
            if (d_wait) begin
              st      <= S_MREQ;
              svc_d   <= 1'b1;
              d_wait  <= 1'b0;
              req_q   <= 1'b1;
              got_ack <= 1'b0;
            end else begin
              st <= S_FIX;
            end
          end
        end
        S_FIX: begin
          if (ph) begin
            st     <= S_RUN;
            i_lat  <= i_addr;
            i_pend <= i_valid;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  a_r1_i_phase_one: assert property (@(posedge clk) disable iff (rst)
    i_rdy |-> !ph_two);

  a_r2_d_phase_two: assert property (@(posedge clk) disable iff (rst)
    d_rdy |-> ph_two);

  a_r4_req_stalls: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> stall);

  a_r4_fix_after_stall: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIX && !ph) |-> $past(st) == S_STALL);

  a_r6_no_unc_fill: assert property (@(posedge clk) disable iff (rst)
    isram_we |-> !is_unc(i_lat));

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r9_instr_first: assert property (@(posedge clk) disable iff (rst)
    (st == S_MREQ && d_wait) |-> !svc_d);
endmodule

// File: tb/tb_l1_split_ctrl.sv
module tb_l1_split_ctrl;
  localparam int IDX_W = 4;
  localparam int TW    = 30 - IDX_W;
  localparam int N     = 1 << IDX_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic ph_two, stall;
  logic [31:0] i_addr, d_addr, d_wdata, i_data, d_rdata;
  logic i_valid, i_rdy, i_map, d_valid, d_we, d_rdy, d_map;
  logic [IDX_W-1:0] isram_idx, dsram_idx;
  logic isram_rvalid, dsram_rvalid, isram_we, dsram_we;
  logic [TW-1:0] isram_rtag, dsram_rtag, isram_wtag, dsram_wtag;
  logic [31:0] isram_rdata, dsram_rdata, isram_wdata, dsram_wdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  l1_split_ctrl #(.IDX_W(IDX_W), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .ph_two(ph_two), .stall(stall),
    .i_addr(i_addr), .i_valid(i_valid), .i_data(i_data), .i_rdy(i_rdy), .i_map(i_map),
    .d_addr(d_addr), .d_valid(d_valid), .d_we(d_we), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .d_rdy(d_rdy), .d_map(d_map),
    .isram_idx(isram_idx), .isram_rvalid(isram_rvalid), .isram_rtag(isram_rtag),
    .isram_rdata(isram_rdata), .isram_we(isram_we), .isram_wtag(isram_wtag),
    .isram_wdata(isram_wdata),
    .dsram_idx(dsram_idx), .dsram_rvalid(dsram_rvalid), .dsram_rtag(dsram_rtag),
    .dsram_rdata(dsram_rdata), .dsram_we(dsram_we), .dsram_wtag(dsram_wtag),
    .dsram_wdata(dsram_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic          iv_m [N];
  logic [TW-1:0] it_m [N];
  logic [31:0]   id_m [N];
  logic          dv_m [N];
  logic [TW-1:0] dt_m [N];
  logic [31:0]   dd_m [N];

  assign isram_rvalid = iv_m[isram_idx];
  assign isram_rtag   = it_m[isram_idx];
  assign isram_rdata  = id_m[isram_idx];
  assign dsram_rvalid = dv_m[dsram_idx];
  assign dsram_rtag   = dt_m[dsram_idx];
  assign dsram_rdata  = dd_m[dsram_idx];

  always @(posedge clk) begin
    if (isram_we) begin
      iv_m[isram_idx] <= 1'b1; it_m[isram_idx] <= isram_wtag; id_m[isram_idx] <= isram_wdata;
    end
    if (dsram_we) begin
      dv_m[dsram_idx] <= 1'b1; dt_m[dsram_idx] <= dsram_wtag; dd_m[dsram_idx] <= dsram_wdata;
    end
  end

  function automatic logic [31:0] memval(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5AC3_3CA5;
  endfunction

  int mem_delay = 0;
  int req_ticks = 0;
  logic ack_done = 1'b0;
  int req_n = 0;
  logic [31:0] req_addr [8];
  logic [31:0] held_addr, last_wa, last_wd;
  int wcnt = 0;
  int addr_moved = 0;

  always @(negedge clk) begin
    if (mem_req && !ack_done) begin
      if (req_ticks == 0) begin
        held_addr = mem_addr;
        if (req_n < 8) req_addr[req_n] = mem_addr;
        req_n = req_n + 1;
      end else if (mem_addr != held_addr) begin
        addr_moved = addr_moved + 1;
      end
      if (req_ticks >= mem_delay) begin
        mem_ack   = 1'b1;
        mem_rdata = memval(mem_addr);
        ack_done  = 1'b1;
        if (mem_we) begin
          wcnt = wcnt + 1; last_wa = mem_addr; last_wd = mem_wdata;
        end
      end
      req_ticks = req_ticks + 1;
    end else begin
      mem_ack = 1'b0;
      if (!mem_req) begin
        ack_done  = 1'b0;
        req_ticks = 0;
      end
    end
  end

  int ntot = 0;
  int nfail = 0;

  task automatic chkeq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  logic got_i, got_d, ph_bad, imap_s, dmap_s;
  logic [31:0] i_val, d_val;
  int i_when, d_when, extra;

  task automatic observe(input int t);
    if (i_rdy) begin got_i = 1'b1; i_val = i_data; i_when = t; if (ph_two) ph_bad = 1'b1; end
    if (d_rdy) begin got_d = 1'b1; d_val = d_rdata; d_when = t; if (!ph_two) ph_bad = 1'b1; end
  endtask

  task automatic access(input logic iv_, input logic [31:0] ia, input logic dv_,
                        input logic [31:0] da, input logic we_, input logic [31:0] wd);
    logic s;
    int t;
    got_i = 0; got_d = 0; ph_bad = 0; i_when = -1; d_when = -1; extra = 0; req_n = 0;
    @(negedge clk);
    if (ph_two) @(negedge clk);
    i_valid = 0; d_valid = 0; d_we = 0; #1; observe(0);
    @(negedge clk); i_valid = iv_; i_addr = ia; #1; observe(1);
    @(negedge clk); i_valid = 0; d_valid = dv_; d_addr = da; d_we = we_; d_wdata = wd;
    #1; observe(2); imap_s = i_map;
    @(negedge clk); d_valid = 0; d_we = 0; #1; observe(3); dmap_s = d_map; s = stall;
    t = 4;
    while (s && extra < 40) begin
      @(negedge clk); #1; observe(t); t++;
      @(negedge clk); #1; observe(t); t++;
      s = stall; extra++;
    end
  endtask

  task automatic set_i(input logic [31:0] a, input logic [31:0] w, input logic v);
    iv_m[a[IDX_W+1:2]] = v; it_m[a[IDX_W+1:2]] = a[31:IDX_W+2]; id_m[a[IDX_W+1:2]] = w;
  endtask

  task automatic set_d(input logic [31:0] a, input logic [31:0] w, input logic v);
    dv_m[a[IDX_W+1:2]] = v; dt_m[a[IDX_W+1:2]] = a[31:IDX_W+2]; dd_m[a[IDX_W+1:2]] = w;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL R4: watchdog, actual hung expected finish");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, wd;
    for (int k = 0; k < N; k++) begin
      iv_m[k] = 0; it_m[k] = '0; id_m[k] = '0; dv_m[k] = 0; dt_m[k] = '0; dd_m[k] = '0;
    end
    mem_ack = 0; mem_rdata = '0;
    i_addr = '0; i_valid = 0; d_addr = '0; d_valid = 0; d_we = 0; d_wdata = '0;
    rst = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chkeq("R10 stall", {31'd0, stall}, 0);
    chkeq("R10 mem_req", {31'd0, mem_req}, 0);
    chkeq("R10 rdy", {30'd0, i_rdy, d_rdy}, 0);
    chkeq("R10 ph_two", {31'd0, ph_two}, 0);
    rst = 0;

    // R1 R3: instruction hits over every index
    for (int k = 0; k < N; k++) begin
      a = 32'h8000_1000 | (k << 2);
      set_i(a, 32'hC0DE_0000 + k * 7, 1);
      access(1, a, 0, '0, 0, '0);
      chkeq("R1 i hit data", i_val, 32'hC0DE_0000 + k * 7);
      chkeq("R1 i return tick", i_when, 2);
      chkeq("R3 i hit no stall", extra + req_n, 0);
      chkeq("R1 phase", {31'd0, ph_bad}, 0);
    end

    // R2 R3: data read hits over every index
    for (int k = 0; k < N; k++) begin
      a = 32'h8000_3000 | (k << 2);
      set_d(a, 32'hDA7A_0000 + k * 11, 1);
      access(0, '0, 1, a, 0, '0);
      chkeq("R2 d hit data", d_val, 32'hDA7A_0000 + k * 11);
      chkeq("R2 d return tick", d_when, 3);
      chkeq("R3 d hit no stall", extra + req_n, 0);
      chkeq("R2 phase", {31'd0, ph_bad}, 0);
    end

    // R3 R4 R5: instruction misses (wrong tag / invalid) under delays
    for (int dl = 0; dl < 4; dl++) begin
      mem_delay = dl;
      a = 32'h8000_2000 | (dl << 2);
      if (dl % 2 == 0) set_i(a ^ 32'h0100_0000, 32'h1111_1111, 1);
      else set_i(a, 32'h2222_2222, 0);
      access(1, a, 0, '0, 0, '0);
      chkeq("R3 i miss req", req_n, 1);
      chkeq("R4 i miss addr", req_addr[0], a);
      chkeq("R4 i miss cycles", extra, 3 + dl / 2);
      chkeq("R4 i fill data", i_val, memval(a));
      chkeq("R4 i fill tick", i_when, 4 + 2 * (1 + dl / 2));
      chkeq("R1 phase", {31'd0, ph_bad}, 0);
      access(1, a, 0, '0, 0, '0);
      chkeq("R5 i refill hit", extra + req_n, 0);
      chkeq("R5 i refill data", i_val, memval(a));
    end

    // R4 R5: data read misses
    for (int dl = 0; dl < 4; dl++) begin
      mem_delay = dl;
      a = 32'h8000_4020 | (dl << 2);
      set_d(a ^ 32'h0040_0000, 32'h3333_3333, 1);
      access(0, '0, 1, a, 0, '0);
      chkeq("R4 d miss cycles", extra, 3 + dl / 2);
      chkeq("R4 d fill data", d_val, memval(a));
      chkeq("R4 d fill tick", d_when, 5 + 2 * (1 + dl / 2));
      access(0, '0, 1, a, 0, '0);
      chkeq("R5 d refill hit", extra + req_n, 0);
      chkeq("R5 d refill data", d_val, memval(a));
    end

    // R6: uncached window bypasses a matching entry and never fills
    mem_delay = 0;
    for (int k = 0; k < 4; k++) begin
      a = 32'hA000_0100 | (k << 2);
      set_i(a, 32'hBAD0_0000 + k, 1);
      set_d(a, 32'hBAD1_0000 + k, 1);
      for (int rep = 0; rep < 2; rep++) begin
        access(1, a, 0, '0, 0, '0);
        chkeq("R6 unc i cycles", extra, 3);
        chkeq("R6 unc i data", i_val, memval(a));
        access(0, '0, 1, a, 0, '0);
        chkeq("R6 unc d cycles", extra, 3);
        chkeq("R6 unc d data", d_val, memval(a));
      end
    end

    // R7: writes
    a = 32'h8000_0014; wd = 32'h1234_5678;
    set_d(a, 32'h0BAD_F00D, 1);
    wcnt = 0;
    access(0, '0, 1, a, 1, wd);
    chkeq("R7 write hit cycles", extra, 3);
    chkeq("R7 write count", wcnt, 1);
    chkeq("R7 write addr", last_wa, a);
    chkeq("R7 write data", last_wd, wd);
    chkeq("R7 no d_rdy on write", {31'd0, got_d}, 0);
    access(0, '0, 1, a, 0, '0);
    chkeq("R7 write hit updated", d_val, wd);
    chkeq("R7 write hit read no req", extra + req_n, 0);
    b = 32'h8000_0418;
    set_d(b, 32'h0, 0);
    access(0, '0, 1, b, 1, 32'hCAFE_0001);
    chkeq("R7 write miss to mem", last_wa, b);
    access(0, '0, 1, b, 0, '0);
    chkeq("R7 no allocate cycles", extra, 3);
    chkeq("R7 no allocate data", d_val, memval(b));
    a = 32'hA000_0020;
    access(0, '0, 1, a, 1, 32'h7777_0000);
    chkeq("R7 unc write addr", last_wa, a);
    chkeq("R7 unc write data", last_wd, 32'h7777_0000);

    // R8: translation flags per segment
    for (int k = 0; k < 6; k++) begin
      logic exp_m;
      case (k)
        0: a = 32'h0000_0040;
        1: a = 32'h7FFF_FFC0;
        2: a = 32'h8000_0040;
        3: a = 32'hA000_0040;
        4: a = 32'hC000_0040;
        default: a = 32'hFFFF_FFC0;
      endcase
      exp_m = !a[31] || (a[31:30] == 2'b11);
      set_i(a, 32'h4444_0000 + k, 1);
      set_d(a, 32'h5555_0000 + k, 1);
      access(1, a, 1, a, 0, '0);
      chkeq("R8 i_map", {31'd0, imap_s}, {31'd0, exp_m});
      chkeq("R8 d_map", {31'd0, dmap_s}, {31'd0, exp_m});
    end

    // R9: simultaneous misses, instruction first, one fix-up
    mem_delay = 1;
    a = 32'h8000_5008; b = 32'h8000_600C;
    set_i(a, 32'h0, 0);
    set_d(b, 32'h0, 0);
    access(1, a, 1, b, 0, '0);
    chkeq("R9 double cycles", extra, 5);
    chkeq("R9 req count", req_n, 2);
    chkeq("R9 first instr", req_addr[0], a);
    chkeq("R9 then data", req_addr[1], b);
    chkeq("R9 i data", i_val, memval(a));
    chkeq("R9 d data", d_val, memval(b));
    chkeq("R9 i tick", i_when, 6);
    chkeq("R9 d tick", d_when, 11);

    // R11: request address held until acknowledge
    chkeq("R11 addr held", addr_moved, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule